// File: doc/BRIEF.md
# Pulsed-Bias Transient Correlator with Two Gated Boxcars

This block drives a repetitive bias sequence for transient capacitance spectroscopy and correlates the relaxation that follows each bias pulse. The device under test rests at a quiet bias code. Each repetition briefly moves it to a fill level, then returns it to the quiet code. While the capacitance relaxes back towards equilibrium, the block reads a capacitance-proportional sample stream.

Two time gates are placed at programmable delays after the pulse ends. The block sums the samples inside the early gate and subtracts the samples inside the late gate. This difference is accumulated over a programmable number of repetitions and then reported with a one-cycle strobe. The two delays form the rate window, and software can move that window between runs.

The fill level is the quiet code plus or minus a programmable step. The sign of the step selects which carrier emission is probed. The settings are captured when a run starts, and a setting set that cannot produce disjoint gates inside the repetition period is refused.

Top module: `dlts_boxcar_correlator`

## Requirements
- R1: After reset the block is idle: `busy`=0, `pulse_active`=0, `result_valid`=0, and `dac_out` equals the `quiet_code` input.
- R2: The fill level is `quiet_code + step_code` when `pulse_up`=1 and `quiet_code - step_code` when `pulse_up`=0. The result saturates at 0 and at 2^DAC_W-1.
- R3: The first pulse begins in the cycle after an accepted `start`. Each pulse lasts `pulse_len` cycles with `dac_out` at the fill level and `pulse_active`=1. Every repetition lasts exactly `period` cycles. `dac_out` holds the latched quiet code for the rest of the repetition.
- R4: Transient index k counts from 0 in the first cycle after a pulse. The early gate adds `sample_in` (signed) for k = `t1` to `t1+gate_len-1`.
- R5: The late gate subtracts `sample_in` for k = `t2` to `t2+gate_len-1`. Samples outside both gates have no effect on the result.
- R6: After `reps` repetitions, `result` holds the accumulated sum. `result_valid` is high for exactly one cycle, in the cycle after the last repetition ends, and `busy` is low in that same cycle. The accumulator then starts the next run from zero.
- R7: `cfg_error` is high whenever any of these holds: `t1+gate_len >= t2`, `period < pulse_len+t2+gate_len`, or any of `pulse_len`, `gate_len`, `reps` is zero. A `start` seen while `cfg_error` is high is ignored.
- R8: During a run, further `start` pulses and changes on the setting inputs have no effect on the timing, the DAC codes or the result of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted when idle and the settings are valid) |
| quiet_code | input | DAC_W | Quiet bias code |
| step_code | input | DAC_W | Pulse step magnitude |
| pulse_up | input | 1 | 1: fill above the quiet code, 0: fill below it |
| pulse_len | input | TW | Pulse length in cycles |
| t1 | input | TW | Early gate delay after the pulse |
| t2 | input | TW | Late gate delay after the pulse |
| gate_len | input | GW | Samples per gate |
| period | input | TW | Repetition period in cycles |
| reps | input | RPW | Repetitions per result |
| sample_in | input | SMP_W | Signed capacitance-proportional sample |
| dac_out | output | DAC_W | Bias code to the DAC |
| pulse_active | output | 1 | High during the fill pulse |
| busy | output | 1 | Run in progress |
| cfg_error | output | 1 | Current settings are invalid |
| result | output | ACC_W | Signed accumulated gate difference |
| result_valid | output | 1 | One-cycle strobe for `result` |

## Verification
The bench uses the default widths: 12-bit DAC and sample, 16-bit timers, 8-bit gate length and repetition count. Under these it draws short pulses, gates and periods, so that many complete runs fit in a short simulation. Because the repetitions are short, the bench can compare the exact cycle of every DAC code, both ends of each gate, and the cycle of the result strobe. Directed runs set the period to its minimum, set the late gate to start right after the early gate's minimum gap, and drive the fill level into saturation at both rails. Further directed cases present each kind of invalid setting.

// File: rtl/dlts_pkg.sv
package dlts_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_TRANS} seq_state_t;

  // Fill level: quiet code shifted by the step, clipped to the DAC range.
  function automatic int fill_level(input int quiet, input int step,
                                    input bit up, input int max_code);
    int v;
    v = up ? quiet + step : quiet - step;
    if (v < 0) v = 0;
    if (v > max_code) v = max_code;
    return v;
  endfunction

  // Window test: k lies in [first, first+len-1].
  function automatic bit in_window(input int k, input int first, input int len);
    return (k >= first) && (k < first + len);
  endfunction

  // Setting check: gates disjoint with a gap, period long enough, no zero counts.
  function automatic bit cfg_bad(input int plen, input int a, input int b,
                                 input int glen, input int per, input int nrep);
    return (plen == 0) || (glen == 0) || (nrep == 0) ||
           (a + glen >= b) || (per < plen + b + glen);
  endfunction

endpackage

// File: rtl/dlts_seq.sv
module dlts_seq #(
  parameter int DAC_W = 12,
  parameter int TW    = 16,
  parameter int GW    = 8,
  parameter int RPW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic [DAC_W-1:0] quiet_in,
  input  logic [DAC_W-1:0] fill_in,
  input  logic [TW-1:0]    pulse_len,
  input  logic [TW-1:0]    t1,
  input  logic [TW-1:0]    t2,
  input  logic [GW-1:0]    gate_len,
  input  logic [TW-1:0]    period,
  input  logic [RPW-1:0]   reps,
  output logic             busy,
  output logic             in_pulse,
  output logic             gate1_on,
  output logic             gate2_on,
  output logic             run_done,
  output logic [DAC_W-1:0] quiet_q,
  output logic [DAC_W-1:0] fill_q
);
  import dlts_pkg::*;

  seq_state_t       state;
  logic [TW-1:0]    cnt;
  logic [RPW-1:0]   rep;
  logic [TW-1:0]    plen_q, t1_q, t2_q, per_q;
  logic [GW-1:0]    glen_q;
  logic [RPW-1:0]   reps_q;
  logic             pulse_last, trans_last, rep_last;

  assign pulse_last = (state == ST_PULSE) && (int'(cnt) == int'(plen_q) - 1);
  assign trans_last = (state == ST_TRANS) &&
                      (int'(cnt) == int'(per_q) - int'(plen_q) - 1);
  assign rep_last   = (int'(rep) == int'(reps_q) - 1);

  assign busy     = (state != ST_IDLE);
  assign in_pulse = (state == ST_PULSE);
  assign gate1_on = (state == ST_TRANS) && in_window(int'(cnt), int'(t1_q), int'(glen_q));
  assign gate2_on = (state == ST_TRANS) && in_window(int'(cnt), int'(t2_q), int'(glen_q));
  assign run_done = trans_last && rep_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rep     <= '0;
      plen_q  <= '0;
      t1_q    <= '0;
      t2_q    <= '0;
      per_q   <= '0;
      glen_q  <= '0;
      reps_q  <= '0;
      quiet_q <= '0;
      fill_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_ok) begin
          state   <= ST_PULSE;
          cnt     <= '0;
          rep     <= '0;
          plen_q  <= pulse_len;
          t1_q    <= t1;
          t2_q    <= t2;
          per_q   <= period;
          glen_q  <= gate_len;
          reps_q  <= reps;
          quiet_q <= quiet_in;
          fill_q  <= fill_in;
        end
        ST_PULSE: begin
          if (pulse_last) begin
            state <= ST_TRANS;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_TRANS: begin
          if (trans_last) begin
            cnt <= '0;
            if (rep_last) state <= ST_IDLE;
            else begin
              state <= ST_PULSE;
              rep   <= rep + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dlts_boxcar.sv
module dlts_boxcar #(
  parameter int SMP_W = 12,
  parameter int ACC_W = 29
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    gate1_on,
  input  logic                    gate2_on,
  input  logic                    run_done,
  input  logic signed [SMP_W-1:0] sample_in,
  output logic signed [ACC_W-1:0] result,
  output logic                    result_valid
);
  logic signed [ACC_W-1:0] acc, acc_next, smp_ext;

  assign smp_ext  = ACC_W'(sample_in);
  assign acc_next = acc + (gate1_on ? smp_ext : '0) - (gate2_on ? smp_ext : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc          <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= run_done;
      if (run_done) begin
        result <= acc_next;
        acc    <= '0;
      end else begin
        acc <= acc_next;
      end
    end
  end

endmodule

// File: rtl/dlts_boxcar_correlator.sv
module dlts_boxcar_correlator #(
  parameter int DAC_W = 12,
  parameter int SMP_W = 12,
  parameter int TW    = 16,
  parameter int GW    = 8,
  parameter int RPW   = 8,
  localparam int ACC_W = SMP_W + GW + RPW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DAC_W-1:0]        quiet_code,
  input  logic [DAC_W-1:0]        step_code,
  input  logic                    pulse_up,
  input  logic [TW-1:0]           pulse_len,
  input  logic [TW-1:0]           t1,
  input  logic [TW-1:0]           t2,
  input  logic [GW-1:0]           gate_len,
  input  logic [TW-1:0]           period,
  input  logic [RPW-1:0]          reps,
  input  logic signed [SMP_W-1:0] sample_in,
  output logic [DAC_W-1:0]        dac_out,
  output logic                    pulse_active,
  output logic                    busy,
  output logic                    cfg_error,
  output logic signed [ACC_W-1:0] result,
  output logic                    result_valid
);
  import dlts_pkg::*;

  localparam int MAX_CODE = (1 << DAC_W) - 1;

  logic             start_ok, gate1_on, gate2_on, run_done;
  logic [DAC_W-1:0] fill_now, quiet_q, fill_q;

  assign cfg_error = cfg_bad(int'(pulse_len), int'(t1), int'(t2),
                             int'(gate_len), int'(period), int'(reps));
  assign start_ok  = start && !busy && !cfg_error;
  assign fill_now  = DAC_W'(fill_level(int'(quiet_code), int'(step_code),
                                       pulse_up, MAX_CODE));

  dlts_seq #(.DAC_W(DAC_W), .TW(TW), .GW(GW), .RPW(RPW)) u_seq (
    .clk, .rst_n, .start_ok,
    .quiet_in (quiet_code), .fill_in (fill_now),
    .pulse_len, .t1, .t2, .gate_len, .period, .reps,
    .busy, .in_pulse (pulse_active), .gate1_on, .gate2_on, .run_done,
    .quiet_q, .fill_q
  );

  dlts_boxcar #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_box (
    .clk, .rst_n, .gate1_on, .gate2_on, .run_done, .sample_in,
    .result, .result_valid
  );

  assign dac_out = pulse_active ? fill_q : (busy ? quiet_q : quiet_code);

endmodule

// File: rtl/dlts_checker.sv
module dlts_checker #(
  parameter int DAC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             pulse_active,
  input logic             cfg_error,
  input logic             result_valid,
  input logic             gate1_on,
  input logic             gate2_on,
  input logic [DAC_W-1:0] dac_out,
  input logic [DAC_W-1:0] quiet_code
);
  AST_IDLE_DAC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dac_out == quiet_code);  // R1
  AST_PULSE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active |-> busy);  // R3
  AST_GATES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate1_on && gate2_on) && !(pulse_active && (gate1_on || gate2_on)));  // R5
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);  // R6
  AST_VALID_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid) |-> !busy && $past(busy));  // R6
  AST_BAD_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_error) |=> !busy);  // R7
endmodule

bind dlts_boxcar_correlator dlts_checker #(.DAC_W(DAC_W)) u_chk (
  .clk, .rst_n, .start, .busy, .pulse_active, .cfg_error, .result_valid,
  .gate1_on, .gate2_on, .dac_out, .quiet_code
);

// File: tb/dlts_boxcar_correlator_tb.sv
`timescale 1ns/1ps
module dlts_boxcar_correlator_tb;
  logic clk = 0, rst_n = 0, start = 0, pulse_up = 0;
  logic [11:0] quiet_code = 0, step_code = 0, dac_out;
  logic [15:0] pulse_len = 0, t1 = 0, t2 = 0, period = 0;
  logic [7:0]  gate_len = 0, reps = 0;
  logic signed [11:0] sample_in = 0;
  logic pulse_active, busy, cfg_error, result_valid;
  logic signed [28:0] result;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  dlts_boxcar_correlator u_dut (.*);

  initial begin
    #4000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic int smp(int sd, int r, int k);
    return ((sd * 7919 + r * 613 + (k + 50) * (k + 50) * 31 + k * 97 + 100000) % 4096) - 2048;
  endfunction

  function automatic int exp_fill(int q, int s, bit up);
    int v = up ? q + s : q - s;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run(int pl, int w, int a, int b, int per, int nr, int q, int s,
                     bit up, int sd);
    int total, expv, dac_bad, dac_first, fill;
    total = per * nr; expv = 0; dac_bad = 0; dac_first = -1;
    fill = exp_fill(q, s, up);
    for (int r = 0; r < nr; r++) begin
      for (int k = a; k < a + w; k++) expv += smp(sd, r, k);
      for (int k = b; k < b + w; k++) expv -= smp(sd, r, k);
    end
    @(negedge clk);
    pulse_len = 16'(pl); gate_len = 8'(w); t1 = 16'(a); t2 = 16'(b);
    period = 16'(per); reps = 8'(nr); quiet_code = 12'(q); step_code = 12'(s);
    pulse_up = up; start = 1;
    @(negedge clk);
    start = 0;
    for (int n = 0; n < total; n++) begin
      int r, k, expd;
      r = n / per; k = (n % per) - pl;
      expd = (k < 0) ? fill : q;
      sample_in = 12'(smp(sd, r, k));
      if (n == 3) begin  // R8: disturb settings and start mid-run
        start = 1; quiet_code = 12'($urandom); step_code = 12'($urandom);
        t1 = 16'($urandom % 8); period = 16'(3); pulse_up = ~up;
      end else start = 0;
      #1;
      if (int'(dac_out) != expd || pulse_active != (k < 0) || !busy || result_valid) begin
        dac_bad++;
        if (dac_first < 0) dac_first = int'(dac_out);
      end
      @(negedge clk);
    end
    start = 0;
    check(dac_bad == 0, "R3/R2/R8 bias sequence", dac_first, fill);
    check(result_valid === 1'b1 && busy === 1'b0, "R6 strobe cycle",
          int'(result_valid), 1);
    check(int'(result) == expv, "R4/R5/R6 result", int'(result), expv);
    @(negedge clk);
    check(result_valid === 1'b0, "R6 strobe width", int'(result_valid), 0);
  endtask

  task automatic bad_cfg(int pl, int w, int a, int b, int per, int nr, string tag);
    @(negedge clk);
    pulse_len = 16'(pl); gate_len = 8'(w); t1 = 16'(a); t2 = 16'(b);
    period = 16'(per); reps = 8'(nr); start = 1;
    #1;
    check(cfg_error === 1'b1, {"R7 flag ", tag}, int'(cfg_error), 1);
    @(negedge clk);
    start = 0;
    check(busy === 1'b0 && pulse_active === 1'b0, {"R7 start refused ", tag},
          int'(busy), 0);
  endtask

  initial begin
    void'($urandom(1234));
    #25;
    check(busy === 0 && pulse_active === 0 && result_valid === 0, "R1 reset state",
          int'(busy), 0);
    quiet_code = 12'd777; #1;
    check(dac_out === 12'd777, "R1 idle dac", int'(dac_out), 777);
    rst_n = 1;
    // Directed: minimum gap and minimum period
    run(1, 1, 0, 2, 4, 3, 2000, 300, 1, 11);
    run(3, 4, 2, 7, 14, 2, 500, 100, 0, 12);
    // R2 saturation at both rails
    run(2, 2, 1, 4, 8, 1, 4000, 500, 1, 13);
    run(2, 2, 1, 4, 8, 1, 100, 500, 0, 14);
    // R6: back-to-back runs, accumulator restarts from zero
    run(2, 3, 0, 5, 12, 4, 1500, 40, 1, 15);
    // Random runs
    for (int i = 0; i < 25; i++) begin
      int pl, w, a, b, per, nr;
      pl = 1 + $urandom % 4; w = 1 + $urandom % 6; a = $urandom % 6;
      b = a + w + 1 + $urandom % 5; per = pl + b + w + $urandom % 5;
      nr = 1 + $urandom % 5;
      run(pl, w, a, b, per, nr, $urandom % 4096, $urandom % 1024, 1'($urandom),
          100 + i);
    end
    // R7 invalid settings
    bad_cfg(2, 3, 1, 4, 20, 2, "gap");
    bad_cfg(2, 3, 1, 3, 20, 2, "overlap");
    bad_cfg(2, 3, 1, 5, 9, 2, "period");
    bad_cfg(0, 3, 1, 5, 20, 2, "pulse0");
    bad_cfg(2, 0, 1, 5, 20, 2, "gate0");
    bad_cfg(2, 3, 1, 5, 20, 0, "reps0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule